// File: doc/BRIEF.md
# Lockable Associative Translation Buffer

This block is a fully associative translation buffer of 64 entries. Each entry pairs a 64-bit tag with a 64-bit translation word. Bit 63 of the translation word marks the entry valid and bit 6 marks it locked. Software drives the block through a single command port. Each command carries an opcode, an address and a write-data word, and the block acknowledges each one with a one-cycle done strobe. Any result appears on the read-data output in the same cycle as the strobe.

An entry is written in one of two ways. First, a register write loads a staging tag register. Then an entry load copies that staged tag and the supplied translation word into the buffer. A load can name its slot through address bits [8:3]. It can also let the block pick a slot: the block prefers the lowest-numbered entry that is not valid, and otherwise the lowest-numbered entry that is not locked. If every entry is both valid and locked, the load is discarded and an error pulse is raised. An associative search returns the tag of the lowest-numbered valid entry whose tag equals the write data. A slot read returns the translation word stored at a named index. All slot selection is combinational, so every command takes exactly one cycle.

Top module: `xtlb`

Opcodes (cmd_op): 0 idle, 1 register write, 2 register read, 3 auto-placed load, 4 indexed load, 5 tag search, 6 slot read. Opcode 7 is treated as idle.

## Requirements
- R1: After reset every translation word reads 0, the staging tag register reads 0, and rd_data, done and full_err are 0.
- R2: A register write whose address bits [6:3] equal 6 loads cmd_wdata into the staging tag register. A register write with any other selector leaves the staging tag register unchanged. A register read with selector 6 returns the staging tag, and a read with any other selector returns 0.
- R3: An auto-placed load (opcode 3) writes the staging tag and cmd_wdata into the lowest-numbered entry whose translation word has bit 63 clear.
- R4: When all entries have bit 63 set, an auto-placed load writes into the lowest-numbered entry whose bit 6 is clear, and it never overwrites an entry with bit 6 set.
- R5: When every entry has both bit 63 and bit 6 set, an auto-placed load changes no entry, and full_err is 1 for exactly the cycle in which done is 1 for that command.
- R6: An indexed load (opcode 4) writes the staging tag and cmd_wdata into the entry selected by address bits [8:3], whether or not that entry is locked.
- R7: A tag search (opcode 5) returns the tag of the lowest-numbered entry that has bit 63 set and a tag equal to cmd_wdata. If no entry qualifies, it returns 0.
- R8: A slot read (opcode 6) returns the translation word of the entry selected by address bits [8:3]. Every command other than a register read, a tag search or a slot read returns 0 on rd_data.
- R9: done is 1 in the cycle after each accepted command (cmd_valid high at a clock edge) and 0 otherwise. The effects of a command are visible from that cycle onward.
- R10: An entry with bit 63 clear never matches a tag search, even when its tag equals the searched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command accepted at this edge |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 16 | Register selector [6:3] or entry index [8:3] |
| cmd_wdata | input | 64 | Write data, translation word or search tag |
| rd_data | output | 64 | Result of the last command |
| done | output | 1 | One-cycle acknowledge |
| full_err | output | 1 | Auto-placed load discarded, all entries locked |

## Verification
The assertions assume that each command is a single-cycle event. They also assume that cmd_op, cmd_addr and cmd_wdata are settled whenever cmd_valid is high, and that nothing is held over into the next cycle. The bench meets this by changing inputs only on falling edges, holding cmd_valid for exactly one cycle per command, and leaving an idle cycle after each command so the done drop can be observed. The bench never drives opcode 7.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_REG_WR    = 3'd1,
    OP_REG_RD    = 3'd2,
    OP_LOAD_AUTO = 3'd3,
    OP_LOAD_IDX  = 3'd4,
    OP_TAG_FIND  = 3'd5,
    OP_SLOT_RD   = 3'd6
  } op_e;

  // test one flag bit of a translation word
  function automatic logic word_flag(input logic [63:0] w, input int unsigned pos);
    return w[pos];
  endfunction
endpackage

// File: rtl/xtlb_prio.sv
module xtlb_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan downward so the last assignment is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xtlb_store.sv
module xtlb_store #(
  parameter int N      = 64,
  parameter int TAG_W  = 64,
  parameter int DATA_W = 64,
  parameter int IW     = $clog2(N)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IW-1:0]                widx,
  input  logic [TAG_W-1:0]             wtag,
  input  logic [DATA_W-1:0]            wdata,
  output logic [N-1:0][TAG_W-1:0]      tags,
  output logic [N-1:0][DATA_W-1:0]     words
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags  <= '0;
      words <= '0;
    end else if (we) begin
      for (int e = 0; e < N; e++) begin
        if (widx == IW'(e)) begin
          tags[e]  <= wtag;
          words[e] <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/xtlb.sv
module xtlb
  import xtlb_pkg::*;
#(
  parameter int N         = 64,
  parameter int TAG_W     = 64,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int VALID_POS = 63,
  parameter int LOCK_POS  = 6,
  parameter int STAGE_SEL = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              full_err
);
  localparam int IW       = $clog2(N);
  localparam int SEL_W    = 4;
  localparam int FIELD_LO = 3;

  op_e op;
  assign op = op_e'(cmd_op);

  logic [N-1:0][TAG_W-1:0]  ent_tag;
  logic [N-1:0][DATA_W-1:0] ent_data;
  logic [TAG_W-1:0]         stage_tag;

  logic [N-1:0] free_vec, unlk_vec, hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_flags
    assign free_vec[g] = !word_flag(64'(ent_data[g]), VALID_POS);
    assign unlk_vec[g] = !word_flag(64'(ent_data[g]), LOCK_POS);
    assign hit_vec[g]  = word_flag(64'(ent_data[g]), VALID_POS) &&
                         (ent_tag[g] == cmd_wdata[TAG_W-1:0]);
  end

  logic          free_found, unlk_found, lk_found;
  logic [IW-1:0] free_idx, unlk_idx, lk_idx;

  xtlb_prio #(.N(N)) u_free (.req(free_vec), .found(free_found), .idx(free_idx));
  xtlb_prio #(.N(N)) u_unlk (.req(unlk_vec), .found(unlk_found), .idx(unlk_idx));
  xtlb_prio #(.N(N)) u_hit  (.req(hit_vec),  .found(lk_found),   .idx(lk_idx));

  // named events for the checker
  logic          is_auto, is_idx, ev_inv, ev_unl, ev_drop, wr_en;
  logic [IW-1:0] slot_sel, victim_idx;
  logic [SEL_W-1:0] reg_sel;

  assign slot_sel   = cmd_addr[FIELD_LO +: IW];
  assign reg_sel    = cmd_addr[FIELD_LO +: SEL_W];
  assign is_auto    = cmd_valid && (op == OP_LOAD_AUTO);
  assign is_idx     = cmd_valid && (op == OP_LOAD_IDX);
  assign ev_inv     = is_auto && free_found;
  assign ev_unl     = is_auto && !free_found && unlk_found;
  assign ev_drop    = is_auto && !free_found && !unlk_found;
  assign wr_en      = ev_inv || ev_unl || is_idx;
  assign victim_idx = is_idx ? slot_sel : (free_found ? free_idx : unlk_idx);

  xtlb_store #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .widx  (victim_idx),
    .wtag  (stage_tag),
    .wdata (cmd_wdata),
    .tags  (ent_tag),
    .words (ent_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_tag <= '0;
    end else if (cmd_valid && op == OP_REG_WR && reg_sel == SEL_W'(STAGE_SEL)) begin
      stage_tag <= cmd_wdata[TAG_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (op)
      OP_REG_RD:   if (reg_sel == SEL_W'(STAGE_SEL)) rd_next = DATA_W'(stage_tag);
      OP_TAG_FIND: if (lk_found) rd_next = DATA_W'(ent_tag[lk_idx]);
      OP_SLOT_RD:  rd_next = ent_data[slot_sel];
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      done     <= 1'b0;
      full_err <= 1'b0;
    end else begin
      done     <= cmd_valid;
      full_err <= ev_drop;
      if (cmd_valid) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/xtlb_chk.sv
module xtlb_chk
  import xtlb_pkg::*;
#(
  parameter int N         = 64,
  parameter int TAG_W     = 64,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int LOCK_POS  = 6,
  parameter int IW        = $clog2(N)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic [ADDR_W-1:0]        cmd_addr,
  input logic [DATA_W-1:0]        cmd_wdata,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     done,
  input logic                     full_err,
  input logic                     ev_inv,
  input logic                     ev_unl,
  input logic                     ev_drop,
  input logic                     lk_found,
  input logic [IW-1:0]            victim_idx,
  input logic [N-1:0][DATA_W-1:0] ent_data
);
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  assert_one_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_inv, ev_unl, ev_drop}));
  assert_auto_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inv || ev_unl) |=> ent_data[$past(victim_idx)] == $past(cmd_wdata));
  assert_victim_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unl |-> !ent_data[victim_idx][LOCK_POS]);
  assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> full_err);
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_err |-> $past(ev_drop));
  assert_drop_nochange_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ent_data == $past(ent_data));
  assert_idx_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_LOAD_IDX)) |=>
      ent_data[$past(cmd_addr[3 +: IW])] == $past(cmd_wdata));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_TAG_FIND) && !lk_found) |=> rd_data == '0);
endmodule

bind xtlb xtlb_chk #(
  .N(N), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_POS(LOCK_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_addr   (cmd_addr),
  .cmd_wdata  (cmd_wdata),
  .rd_data    (rd_data),
  .done       (done),
  .full_err   (full_err),
  .ev_inv     (ev_inv),
  .ev_unl     (ev_unl),
  .ev_drop    (ev_drop),
  .lk_found   (lk_found),
  .victim_idx (victim_idx),
  .ent_data   (ent_data)
);

// File: tb/xtlb_tb.sv
module xtlb_tb;
  localparam int N = 64;
  localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LB = 64'h0000_0000_0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic [63:0] rd_data;
  logic        done, full_err;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] m_tag [N];
  logic [63:0] m_data[N];
  logic [63:0] m_stage;

  always #5 clk = ~clk;

  xtlb u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
    .done(done), .full_err(full_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] at(input int k);
    return 16'(k << 3);
  endfunction

  // issue one command, predict results from the model, then compare
  task automatic issue(input string req, input logic [2:0] op,
                       input logic [15:0] a, input logic [63:0] wd);
    logic [63:0] exp_rd = '0;
    logic        exp_err = 1'b0;
    int          slot = -1;
    int          k = int'(a[8:3]);
    case (op)
      3'd1: if (a[6:3] == 4'd6) m_stage = wd;
      3'd2: exp_rd = (a[6:3] == 4'd6) ? m_stage : 64'd0;
      3'd3: begin
        for (int i = 0; i < N; i++) if (slot < 0 && !m_data[i][63]) slot = i;
        for (int i = 0; i < N; i++) if (slot < 0 && !m_data[i][6]) slot = i;
        if (slot < 0) exp_err = 1'b1;
        else begin m_tag[slot] = m_stage; m_data[slot] = wd; end
      end
      3'd4: begin m_tag[k] = m_stage; m_data[k] = wd; end
      3'd5: begin
        for (int i = N - 1; i >= 0; i--)
          if (m_data[i][63] && m_tag[i] == wd) exp_rd = m_tag[i];
      end
      3'd6: exp_rd = m_data[k];
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    check({req, "/R9 done"}, 64'(done), 64'd1);
    check({req, "/R5 err"}, 64'(full_err), 64'(exp_err));
    check({req, "/R8 rd"}, rd_data, exp_rd);
    @(negedge clk);
    check("R9 done low", 64'(done), 64'd0);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) issue(req, 3'd6, at(i), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; end
    m_stage = '0;
    repeat (3) @(negedge clk);
    check("R1 done", 64'(done), 64'd0);
    check("R1 err", 64'(full_err), 64'd0);
    check("R1 rd", rd_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1");
    issue("R1 stage", 3'd2, 16'h0030, 64'd0);

    // R2: other selectors ignored, selector 6 loads the staging tag
    issue("R2", 3'd1, 16'h0028, 64'h1111_2222_3333_4444);
    issue("R2", 3'd2, 16'h0028, 64'd0);
    issue("R2", 3'd2, 16'h0030, 64'd0);
    issue("R2", 3'd1, 16'h0030, 64'hDEAD_BEEF_0000_0001);
    issue("R2", 3'd2, 16'h0030, 64'd0);

    // R3: fill every slot in order, every third one locked
    for (int k = 0; k < N; k++) begin
      issue("R2", 3'd1, 16'h0030, 64'hA500_0000_0000_0000 | 64'(k * 7));
      issue("R3", 3'd3, 16'h0000, VB | ((k % 3 == 0) ? LB : 64'd0) | 64'(k << 12));
    end
    read_all("R3");

    // R6: indexed overwrite ignores the lock; clear valid on two slots
    issue("R6", 3'd1, 16'h0030, 64'h0BAD_0000_0000_0027);
    issue("R6", 3'd4, at(39), LB | 64'h27);
    issue("R6", 3'd4, at(10), 64'h0A);
    issue("R6", 3'd6, at(39), 64'd0);

    // R3 then R4: refill holes, then pick lowest unlocked
    issue("R3", 3'd1, 16'h0030, 64'h7777_0000_0000_0001);
    issue("R3", 3'd3, 16'h0000, VB | 64'h100);
    issue("R3", 3'd3, 16'h0000, VB | 64'h200);
    issue("R4", 3'd3, 16'h0000, VB | 64'h300);
    issue("R4", 3'd3, 16'h0000, VB | LB | 64'h400);
    read_all("R4");

    // R10 / R7: searches
    issue("R7", 3'd5, 16'h0000, 64'h7777_0000_0000_0001);
    issue("R7", 3'd5, 16'h0000, 64'hA500_0000_0000_0000 | 64'(20 * 7));
    issue("R7", 3'd5, 16'h0000, 64'h5555_5555_5555_5555);
    issue("R10", 3'd1, 16'h0030, 64'h0C0F_FEE0_0000_0000);
    issue("R10", 3'd4, at(5), LB);
    issue("R10", 3'd5, 16'h0000, 64'h0C0F_FEE0_0000_0000);
    issue("R10", 3'd4, at(50), VB);
    issue("R10", 3'd5, 16'h0000, 64'h0C0F_FEE0_0000_0000);

    // R5: lock everything, auto load must be dropped
    for (int k = 0; k < N; k++) issue("R5", 3'd4, at(k), VB | LB | 64'(k));
    issue("R5", 3'd3, 16'h0000, VB | 64'h999);
    issue("R5", 3'd3, 16'h0000, 64'h0);
    read_all("R5");
    issue("R8", 3'd0, 16'h0000, 64'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule